// File: doc/BRIEF.md
# Port Pin Mode Controller

This block governs one general-purpose I/O port of `WIDTH` pins (8 by default). Software sets four state elements through a small write channel: a per-pin output latch, a per-pin drive-style register (push-pull or open-drain), a per-pin input-style register (digital or analog) and a single control bit that turns off every weak pullup on the port. From these settings and a set of per-pin override signals supplied by the peripheral routing fabric, the block computes three pad controls for each pin: drive-low enable, drive-high enable and pullup enable. It also returns the pin levels through a synchronizer, and it raises a per-pin skip flag so the routing fabric passes over pins held in analog mode.

The routing fabric can give a pin to a peripheral output. That peripheral's value then replaces the latch as the drive source. The fabric can mark a pin as a peripheral input, which turns off both of that pin's drivers. It can also force open-drain on the pins that carry two-wire bus data or clock, or a serial receive line in its shift-register mode. Pad outputs are combinational from registered settings and the live override inputs. Register writes take effect from the cycle after acceptance.

The write channel is valid/ready. `cfg_ready` is held high whenever the block is out of reset, so the channel applies no back-pressure. A write is accepted on any rising clock edge where `cfg_valid` and `cfg_ready` are both high. The address and data must be stable while `cfg_valid` is high.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the latch is all ones, every pin is open-drain and digital, and pullups are enabled. So `pad_drv_lo` and `pad_drv_hi` are 0, `pad_pu_en` is all ones and `xbar_skip` is 0.
- R2: `cfg_ready` is 1 out of reset. An accepted write updates the register selected by `cfg_addr` in the next cycle: 0 is the latch, 1 the drive style (1 = push-pull), 2 the input style (1 = digital, 0 = analog), and 3 the control word with bit 0 = pullup disable. When `cfg_valid` is 0, no register changes.
- R3: On a push-pull pin with no forced open-drain and no peripheral input, a drive value of 1 gives `pad_drv_hi`=1 and `pad_drv_lo`=0. A drive value of 0 gives `pad_drv_lo`=1 and `pad_drv_hi`=0.
- R4: An open-drain pin never asserts `pad_drv_hi`. It asserts `pad_drv_lo` exactly when its drive value is 0 and it is not a peripheral input.
- R5: A pin with `xbar_force_od` set never asserts `pad_drv_hi`, whatever its drive-style bit says.
- R6: When `xbar_out_en` is set for a pin, `xbar_out_val` replaces the latch bit as that pin's drive value.
- R7: When `xbar_in_en` is set for a pin, both `pad_drv_lo` and `pad_drv_hi` are 0 for that pin.
- R8: `pad_pu_en` is 1 for a pin exactly when the global pullup disable is 0, the pin is digital, and the pin is not asserting `pad_drv_lo`.
- R9: An analog pin reads 0 on `pin_rd`, raises `xbar_skip` and has its pullup off. Its drivers still follow its drive style and drive value.
- R10: For a digital pin, `pin_rd` equals the value of `pad_in` two rising clock edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Register write request |
| cfg_ready | output | 1 | Write accepted when high together with cfg_valid |
| cfg_addr | input | 2 | Register select (0 latch, 1 drive style, 2 input style, 3 control) |
| cfg_wdata | input | WIDTH | Write data |
| xbar_out_en | input | WIDTH | Pin assigned to a peripheral output |
| xbar_out_val | input | WIDTH | Peripheral output value per pin |
| xbar_in_en | input | WIDTH | Pin assigned to a peripheral input |
| xbar_force_od | input | WIDTH | Pin carries a function that requires open-drain |
| pad_in | input | WIDTH | Raw pin levels from the pads |
| pad_drv_lo | output | WIDTH | Pull-down driver enable |
| pad_drv_hi | output | WIDTH | Pull-up driver enable |
| pad_pu_en | output | WIDTH | Weak pullup enable |
| pin_rd | output | WIDTH | Synchronized digital pin levels |
| xbar_skip | output | WIDTH | Pin is analog; routing fabric passes over it |

## Verification
The bench targets a push-pull pin that also has forced open-drain set. A design that ignores the force would drive the bus line high and fight other devices. It checks a pin that is both a peripheral output and a peripheral input, where leaking drivers would contend with the external source. It checks analog pins with the latch at 0: a design that switched off the drivers in analog mode, or kept the pullup on, or let digital reads through, would show a wrong drive, pullup or read value. It also checks the pullup on a pin driving low and the exact two-edge read latency, which catch a pullup that contends with its own driver and a synchronizer of the wrong depth.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int unsigned CFG_ADDR_W = 2;

  typedef enum logic [CFG_ADDR_W-1:0] {
    SEL_LATCH    = 2'd0,
    SEL_DRV_MODE = 2'd1,
    SEL_IN_MODE  = 2'd2,
    SEL_CTRL     = 2'd3
  } cfg_sel_e;

  localparam int unsigned CTRL_PU_DIS_BIT = 0;

  typedef struct packed {
    logic lo;
    logic hi;
    logic pu;
  } pad_ctl_t;

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_valid,
  output logic                  cfg_ready,
  input  logic [CFG_ADDR_W-1:0] cfg_addr,
  input  logic [WIDTH-1:0]      cfg_wdata,
  output logic [WIDTH-1:0]      latch_q,
  output logic [WIDTH-1:0]      drv_mode_q,
  output logic [WIDTH-1:0]      in_mode_q,
  output logic                  pu_dis_q
);

  logic     accept;
  cfg_sel_e sel;

  assign sel    = cfg_sel_e'(cfg_addr);
  assign accept = cfg_valid & cfg_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_ready <= 1'b0;
    end else begin
      cfg_ready <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q    <= '1;
      drv_mode_q <= '0;
      in_mode_q  <= '1;
      pu_dis_q   <= 1'b0;
    end else if (accept) begin
      unique case (sel)
        SEL_LATCH:    latch_q    <= cfg_wdata;
        SEL_DRV_MODE: drv_mode_q <= cfg_wdata;
        SEL_IN_MODE:  in_mode_q  <= cfg_wdata;
        SEL_CTRL:     pu_dis_q   <= cfg_wdata[CTRL_PU_DIS_BIT];
        default:      ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q[0] <= '0;
    end else begin
      stage_q[0] <= d;
    end
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else begin
        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_port_pin.sv
module gpio_port_pin
  import gpio_port_pkg::*;
(
  input  logic     latch_bit,
  input  logic     push_pull,
  input  logic     digital,
  input  logic     pu_dis,
  input  logic     per_out_en,
  input  logic     per_out_val,
  input  logic     per_in_en,
  input  logic     force_od,
  input  logic     sync_level,
  output pad_ctl_t ctl,
  output logic     rd,
  output logic     skip
);

  logic drive_val;
  logic eff_pp;

  always_comb begin
    drive_val = per_out_en ? per_out_val : latch_bit;
    eff_pp    = push_pull & ~force_od;
    ctl.lo    = ~per_in_en & ~drive_val;
    ctl.hi    = ~per_in_en & eff_pp & drive_val;
    ctl.pu    = ~pu_dis & digital & ~ctl.lo;
    rd        = sync_level & digital;
    skip      = ~digital;
  end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_valid,
  output logic                  cfg_ready,
  input  logic [CFG_ADDR_W-1:0] cfg_addr,
  input  logic [WIDTH-1:0]      cfg_wdata,
  input  logic [WIDTH-1:0]      xbar_out_en,
  input  logic [WIDTH-1:0]      xbar_out_val,
  input  logic [WIDTH-1:0]      xbar_in_en,
  input  logic [WIDTH-1:0]      xbar_force_od,
  input  logic [WIDTH-1:0]      pad_in,
  output logic [WIDTH-1:0]      pad_drv_lo,
  output logic [WIDTH-1:0]      pad_drv_hi,
  output logic [WIDTH-1:0]      pad_pu_en,
  output logic [WIDTH-1:0]      pin_rd,
  output logic [WIDTH-1:0]      xbar_skip
);

  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] drv_mode_q;
  logic [WIDTH-1:0] in_mode_q;
  logic             pu_dis_q;
  logic [WIDTH-1:0] sync_q;

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_valid  (cfg_valid),
    .cfg_ready  (cfg_ready),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .latch_q    (latch_q),
    .drv_mode_q (drv_mode_q),
    .in_mode_q  (in_mode_q),
    .pu_dis_q   (pu_dis_q)
  );

  gpio_port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (sync_q)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    pad_ctl_t ctl;
    gpio_port_pin u_pin (
      .latch_bit   (latch_q[i]),
      .push_pull   (drv_mode_q[i]),
      .digital     (in_mode_q[i]),
      .pu_dis      (pu_dis_q),
      .per_out_en  (xbar_out_en[i]),
      .per_out_val (xbar_out_val[i]),
      .per_in_en   (xbar_in_en[i]),
      .force_od    (xbar_force_od[i]),
      .sync_level  (sync_q[i]),
      .ctl         (ctl),
      .rd          (pin_rd[i]),
      .skip        (xbar_skip[i])
    );
    assign pad_drv_lo[i] = ctl.lo;
    assign pad_drv_hi[i] = ctl.hi;
    assign pad_pu_en[i]  = ctl.pu;
  end

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_ready,
  input logic [WIDTH-1:0] xbar_in_en,
  input logic [WIDTH-1:0] xbar_force_od,
  input logic [WIDTH-1:0] pad_in,
  input logic [WIDTH-1:0] pad_drv_lo,
  input logic [WIDTH-1:0] pad_drv_hi,
  input logic [WIDTH-1:0] pad_pu_en,
  input logic [WIDTH-1:0] pin_rd,
  input logic [WIDTH-1:0] xbar_skip
);

  logic [1:0] edges_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edges_q <= '0;
    end else if (edges_q != 2'd3) begin
      edges_q <= edges_q + 2'd1;
    end
  end

  AST_READY_OUT_OF_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (edges_q != 2'd0) |-> cfg_ready) else $error("ready low"); // R2
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_drv_lo & pad_drv_hi) == '0) else $error("both drivers"); // R3
  AST_FORCED_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_drv_hi & xbar_force_od) == '0) else $error("high on forced od"); // R5
  AST_INPUT_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_drv_lo | pad_drv_hi) & xbar_in_en) == '0) else $error("input driven"); // R7
  AST_PULLUP_NOT_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu_en & pad_drv_lo) == '0) else $error("pullup on low"); // R8
  AST_ANALOG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_rd | pad_pu_en) & xbar_skip) == '0) else $error("analog leak"); // R9
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (edges_q >= 2'd2) |-> (pin_rd == ($past(pad_in, 2) & ~xbar_skip))) else $error("read latency"); // R10

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_ready     (cfg_ready),
  .xbar_in_en    (xbar_in_en),
  .xbar_force_od (xbar_force_od),
  .pad_in        (pad_in),
  .pad_drv_lo    (pad_drv_lo),
  .pad_drv_hi    (pad_drv_hi),
  .pad_pu_en     (pad_pu_en),
  .pin_rd        (pin_rd),
  .xbar_skip     (xbar_skip)
);

// File: tb/gpio_port_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_port_ctrl_tb;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_valid = 1'b0;
  logic         cfg_ready;
  logic [1:0]   cfg_addr = '0;
  logic [W-1:0] cfg_wdata = '0;
  logic [W-1:0] xbar_out_en = '0, xbar_out_val = '0, xbar_in_en = '0, xbar_force_od = '0;
  logic [W-1:0] pad_in = '0;
  logic [W-1:0] pad_drv_lo, pad_drv_hi, pad_pu_en, pin_rd, xbar_skip;

  gpio_port_ctrl #(.WIDTH(W)) u_dut (.*);

  always #5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model of the register state
  logic [W-1:0] m_latch = '1, m_pp = '0, m_dig = '1;
  logic         m_pudis = 1'b0;
  logic         pend_v = 1'b0;
  logic [1:0]   pend_a = '0;
  logic [W-1:0] pend_d = '0;
  logic [W-1:0] hist1 = '0, hist2 = '0, last_pad = '0;

  task automatic cmp(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] e_src();
    return (xbar_out_en & xbar_out_val) | (~xbar_out_en & m_latch);
  endfunction
  function automatic logic [W-1:0] e_lo();
    return ~xbar_in_en & ~e_src();
  endfunction
  function automatic logic [W-1:0] e_hi();
    return ~xbar_in_en & m_pp & ~xbar_force_od & e_src();
  endfunction
  function automatic logic [W-1:0] e_pu();
    return {W{~m_pudis}} & m_dig & ~e_lo();
  endfunction

  task automatic check_all();
    string thi;
    thi = (|xbar_force_od) ? "R5" : (|xbar_in_en) ? "R7" : (|xbar_out_en) ? "R6" : "R3";
    cmp(thi, "pad_drv_hi", pad_drv_hi, e_hi());
    cmp((|xbar_in_en) ? "R7" : "R4", "pad_drv_lo", pad_drv_lo, e_lo());
    cmp("R8", "pad_pu_en", pad_pu_en, e_pu());
    cmp("R9", "xbar_skip", xbar_skip, ~m_dig);
    cmp("R10", "pin_rd", pin_rd, hist2 & m_dig);
    cmp("R2", "cfg_ready", {{(W-1){1'b0}}, cfg_ready}, {{(W-1){1'b0}}, 1'b1});
  endtask

  task automatic step(input logic wv, input logic [1:0] wa, input logic [W-1:0] wd,
                      input logic [W-1:0] oe, input logic [W-1:0] ov,
                      input logic [W-1:0] ie, input logic [W-1:0] fo,
                      input logic [W-1:0] pad);
    @(negedge clk);
    if (pend_v) begin
      case (pend_a)
        2'd0: m_latch = pend_d;
        2'd1: m_pp    = pend_d;
        2'd2: m_dig   = pend_d;
        default: m_pudis = pend_d[0];
      endcase
    end
    hist2 = hist1;
    hist1 = last_pad;
    check_all();
    cfg_valid = wv; cfg_addr = wa; cfg_wdata = wd;
    xbar_out_en = oe; xbar_out_val = ov; xbar_in_en = ie; xbar_force_od = fo;
    pad_in = pad;
    pend_v = wv; pend_a = wa; pend_d = wd; last_pad = pad;
  endtask

  task automatic idle(input logic [W-1:0] pad);
    step(1'b0, 2'd0, 8'h00, xbar_out_en, xbar_out_val, xbar_in_en, xbar_force_od, pad);
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    step(1'b1, a, d, xbar_out_en, xbar_out_val, xbar_in_en, xbar_force_od, pad_in);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state seen at the pads
    @(negedge clk);
    cmp("R1", "pad_drv_lo", pad_drv_lo, '0);
    cmp("R1", "pad_drv_hi", pad_drv_hi, '0);
    cmp("R1", "pad_pu_en", pad_pu_en, '1);
    cmp("R1", "xbar_skip", xbar_skip, '0);

    // R2: a write with cfg_valid low must not land (model left unchanged)
    step(1'b0, 2'd0, 8'h00, '0, '0, '0, '0, 8'h00);
    idle(8'h00);
    // R2 / R3: push-pull on low nibble, latch pattern
    wr(2'd1, 8'h0F);
    wr(2'd0, 8'hA5);
    idle(8'hFF);
    idle(8'h3C);
    // R5: force open-drain on push-pull pins driving 1
    step(1'b0, 2'd0, 8'h00, '0, '0, '0, 8'h05, 8'h3C);
    idle(8'h3C);
    // R6: peripheral drives replace the latch
    step(1'b0, 2'd0, 8'h00, 8'h0F, 8'h0A, '0, '0, 8'h00);
    idle(8'h00);
    // R7: pin both peripheral output and input: drivers off
    step(1'b0, 2'd0, 8'h00, 8'h03, 8'h01, 8'h03, '0, 8'h00);
    idle(8'h00);
    // R9: analog pins with latch 0 keep low drive, read 0, skip set
    step(1'b0, 2'd0, 8'h00, '0, '0, '0, '0, 8'hFF);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h0F);
    idle(8'hFF);
    idle(8'hFF);
    // R8: global pullup disable, then re-enable
    wr(2'd3, 8'h01);
    idle(8'h55);
    wr(2'd3, 8'hFE);
    idle(8'h55);
    wr(2'd2, 8'hFF);
    idle(8'hAA);

    // random mix
    for (int k = 0; k < 4000; k++) begin
      logic [W-1:0] oe, ie, fo;
      oe = W'($urandom & $urandom);
      ie = W'($urandom & $urandom & $urandom);
      fo = W'($urandom & $urandom);
      step(($urandom % 3) == 0, 2'($urandom), W'($urandom), oe, W'($urandom), ie, fo, W'($urandom));
    end
    idle(8'h00);
    idle(8'h00);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule